// File: doc/BRIEF.md
# Trigger-Latency Pipeline with Overlap-Tolerant Frame Buffers

This block delays every incoming sample word through a rotating buffer. The length of the delay is set at run time and covers the time the first-level trigger needs to decide. A sample word is twelve data bits plus a corruption marker and two pile-up flags. Each word is protected by a single-error-correcting Hamming code while it is stored. When a trigger accept arrives, the block copies a frame of consecutive words from the delayed stream into a frame buffer. There are eight frame buffers, taken in ring order. Location 0 of each buffer is written last and holds a header: the crossing number captured at the accept, plus the OR of the flags seen across the frame.

Every buffer has its own writer. An accept that arrives while earlier frames are still being written opens another buffer, and the samples the frames share go into every open buffer in the same cycle. Each trigger therefore gets a complete frame, even when accepts come back to back. A readout agent picks a buffer and an address, reads the corrected word one clock later, and hands the buffer back with a release strobe. An accept that finds no buffer to take is dropped and flagged. For test, a bypass mode skips the delay so the frame captures the live input.

Top module: `trig_pipe_derand`

## Requirements
- R1: After reset, `frame_rdy` and `ovf_err` are 0, and `rd_data` and `rd_corr` are 0.
- R2: Call the sample present at the clock edge where an accept is sampled "sample n". Frame address 1 then holds sample n−L. L is `delay_len`, clamped to the range 4..256 (0 gives 4, 300 gives 256).
- R3: With `bypass` high the delay is zero, so frame address 1 holds sample n itself.
- R4: The frame length F is `frame_len`, clamped to 2..16. Addresses 1..F−1 hold consecutive samples n−L .. n−L+F−2. The header goes to address 0 on edge F−1 after the accept, and the same edge sets the buffer's `frame_rdy` bit.
- R5: A sample word reads out as [11:0] data, [12] light pile-up flag, [13] severe pile-up flag, [14] corruption marker.
- R6: The header reads out as [11:0] `bx_num` at the accept edge, [13:12] the OR of the pile-up flags of the frame's samples, and [14] the OR of their corruption markers.
- R7: Accepts take buffers in ring order 0,1,…,7,0…, starting at buffer 0 after reset.
- R8: An accept that arrives while other frames are still being written opens the next buffer. A shared sample is written into every open buffer, and up to eight frames can be written at the same time.
- R9: An accept whose ring-next buffer is still being written or still awaits release is dropped. `ovf_err` is then high for exactly the one cycle after that edge, and no buffer content or `frame_rdy` bit changes.
- R10: `rd_release` with `rd_sel` naming a ready buffer clears that buffer's `frame_rdy` bit at the edge. If an accept targets the same buffer in that same cycle, the accept is taken.
- R11: `rd_data` and `rd_corr` show the word at `rd_sel`/`rd_addr` one clock after those are sampled. An intact word reads out with `rd_corr` at 0, and a word with a single-bit error reads out corrected with `rd_corr` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | 12 | Sample data |
| smp_bad | input | 1 | Corruption marker of the sample |
| smp_pu | input | 2 | Pile-up flags (bit 0 light, bit 1 severe) |
| delay_len | input | 9 | Pipeline delay in clocks |
| bypass | input | 1 | Zero-delay test path |
| frame_len | input | 5 | Frame length including header |
| accept | input | 1 | Trigger accept strobe |
| bx_num | input | 12 | Current crossing number |
| rd_sel | input | 3 | Buffer selected for readout |
| rd_addr | input | 4 | Word address within the buffer |
| rd_release | input | 1 | Hand the selected buffer back |
| rd_data | output | 15 | Corrected word read |
| rd_corr | output | 1 | Non-fatal error: a single bit was corrected |
| frame_rdy | output | 8 | Per-buffer complete-and-unread flags |
| ovf_err | output | 1 | Accept dropped because no buffer was free |

## Verification
Two events can land on the same buffer in the same cycle: a release of the buffer that is next in the ring, and a new accept that wants it. The bench first fills all eight buffers with back-to-back accepts. It then raises the release and the accept on the same edge and expects no overflow pulse, a set ready bit and a fresh header. A second coincidence is tested by placing a second accept exactly on the cycle of the first frame's header write. Both frames must then read back whole.

// File: rtl/trig_pipe_derand.sv
module trig_pipe_derand #(
  parameter int DW   = 12,
  parameter int NBUF = 8,
  parameter int FMAX = 16,
  parameter int DMAX = 256
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DW-1:0]               smp_data,
  input  logic                        smp_bad,
  input  logic [1:0]                  smp_pu,
  input  logic [$clog2(DMAX):0]       delay_len,
  input  logic                        bypass,
  input  logic [$clog2(FMAX):0]       frame_len,
  input  logic                        accept,
  input  logic [DW-1:0]               bx_num,
  input  logic [$clog2(NBUF)-1:0]     rd_sel,
  input  logic [$clog2(FMAX)-1:0]     rd_addr,
  input  logic                        rd_release,
  output logic [DW+2:0]               rd_data,
  output logic                        rd_corr,
  output logic [NBUF-1:0]             frame_rdy,
  output logic                        ovf_err
);
  localparam int WW  = DW + 3;
  localparam int PB  = $clog2(WW + $clog2(WW) + 1);
  localparam int CW  = WW + PB;
  localparam int PAW = $clog2(DMAX);
  localparam int DLW = PAW + 1;
  localparam int FAW = $clog2(FMAX);
  localparam int FLW = FAW + 1;
  localparam int BW  = $clog2(NBUF);

  function automatic logic [CW-1:0] ham_enc(input logic [WW-1:0] d);
    logic [CW-1:0] c;
    int j;
    logic x;
    c = '0;
    j = 0;
    for (int p = 1; p <= CW; p++)
      if ((p & (p - 1)) != 0) begin
        c[p-1] = d[j];
        j++;
      end
    for (int k = 0; k < PB; k++) begin
      x = 1'b0;
      for (int p = 1; p <= CW; p++)
        if (((p >> k) & 1) == 1 && (p & (p - 1)) != 0) x = x ^ c[p-1];
      c[(1 << k) - 1] = x;
    end
    return c;
  endfunction

  function automatic logic [CW-1:0] ham_fix(input logic [CW-1:0] c);
    int s;
    logic [CW-1:0] f;
    s = 0;
    for (int p = 1; p <= CW; p++)
      if (c[p-1]) s = s ^ p;
    f = c;
    if (s != 0 && s <= CW) f[s-1] = ~f[s-1];
    return f;
  endfunction

  function automatic logic [WW-1:0] ham_data(input logic [CW-1:0] c);
    logic [WW-1:0] d;
    int j;
    d = '0;
    j = 0;
    for (int p = 1; p <= CW; p++)
      if ((p & (p - 1)) != 0) begin
        d[j] = c[p-1];
        j++;
      end
    return d;
  endfunction

  function automatic logic [2:0] tag_of(input logic [CW-1:0] c);
    logic [CW-1:0] f;
    f = ham_fix(c);
    return {f[CW-1], f[CW-2], f[CW-3]};
  endfunction

  logic [CW-1:0]  pmem [DMAX];
  logic [PAW-1:0] ptr;
  logic [DLW-1:0] eff_d;
  logic [FLW-1:0] eff_f;
  logic [CW-1:0]  in_cw, pipe_cw;
  logic [2:0]     pipe_tag;

  assign eff_d = (delay_len < DLW'(4)) ? DLW'(4) :
                 (delay_len > DLW'(DMAX)) ? DLW'(DMAX) : delay_len;
  assign eff_f = (frame_len < FLW'(2)) ? FLW'(2) :
                 (frame_len > FLW'(FMAX)) ? FLW'(FMAX) : frame_len;
  assign in_cw    = ham_enc({smp_bad, smp_pu, smp_data});
  assign pipe_cw  = bypass ? in_cw : pmem[ptr];
  assign pipe_tag = tag_of(pipe_cw);

  always_ff @(posedge clk) pmem[ptr] <= in_cw;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ptr <= '0;
    else if ({1'b0, ptr} >= eff_d - DLW'(1)) ptr <= '0;
    else ptr <= ptr + 1'b1;

  logic [CW-1:0]  dmem [NBUF*FMAX];
  logic [NBUF-1:0] wact;
  logic [FLW-1:0] wcnt [NBUF];
  logic [DW-1:0]  hbx  [NBUF];
  logic [2:0]     hacc [NBUF];
  logic [BW-1:0]  nxt;
  logic           avail, start;
  logic [NBUF-1:0] we;
  logic [FAW-1:0] wa [NBUF];
  logic [CW-1:0]  wd [NBUF];

  assign avail = ~(wact[nxt] | frame_rdy[nxt]) |
                 (rd_release & (rd_sel == nxt) & frame_rdy[nxt]);
  assign start = accept & avail;

  for (genvar b = 0; b < NBUF; b++) begin : g_wr
    logic mine, hdr_now;
    assign mine    = start && (nxt == BW'(b));
    assign hdr_now = wact[b] && (wcnt[b] == eff_f);
    assign we[b]   = mine | wact[b];
    assign wa[b]   = mine ? FAW'(1) : hdr_now ? '0 : wcnt[b][FAW-1:0];
    assign wd[b]   = hdr_now ? ham_enc({hacc[b], hbx[b]}) : pipe_cw;
  end

  always_ff @(posedge clk)
    for (int b = 0; b < NBUF; b++)
      if (we[b]) dmem[{BW'(b), wa[b]}] <= wd[b];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wact <= '0;
      frame_rdy <= '0;
      nxt <= '0;
      ovf_err <= 1'b0;
      for (int b = 0; b < NBUF; b++) begin
        wcnt[b] <= '0;
        hbx[b]  <= '0;
        hacc[b] <= '0;
      end
    end else begin
      ovf_err <= accept & ~avail;
      if (start) nxt <= nxt + 1'b1;
      for (int b = 0; b < NBUF; b++) begin
        if (rd_release && rd_sel == BW'(b) && frame_rdy[b]) frame_rdy[b] <= 1'b0;
        if (start && nxt == BW'(b)) begin
          wact[b] <= 1'b1;
          wcnt[b] <= FLW'(2);
          hbx[b]  <= bx_num;
          hacc[b] <= pipe_tag;
        end else if (wact[b]) begin
          if (wcnt[b] == eff_f) begin
            wact[b] <= 1'b0;
            frame_rdy[b] <= 1'b1;
          end else begin
            wcnt[b] <= wcnt[b] + 1'b1;
            hacc[b] <= hacc[b] | pipe_tag;
          end
        end
      end
    end

  logic [CW-1:0] rd_q, rd_fix;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_q <= '0;
    else rd_q <= dmem[{rd_sel, rd_addr}];

  assign rd_fix  = ham_fix(rd_q);
  assign rd_data = ham_data(rd_fix);
  assign rd_corr = (rd_fix != rd_q);
endmodule

// File: rtl/trig_pipe_derand_chk.sv
module trig_pipe_derand_chk #(
  parameter int NBUF = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            accept,
  input logic            ovf_err,
  input logic            rd_release,
  input logic            rd_corr,
  input logic [NBUF-1:0] frame_rdy
);
  // R9
  ovf_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> $past(accept));

  // R10
  rdy_clear_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(frame_rdy) & ~frame_rdy)) |-> $past(rd_release));

  // R10
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones($past(frame_rdy) & ~frame_rdy) <= 1);

  // R11
  intact_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_corr);
endmodule

bind trig_pipe_derand trig_pipe_derand_chk #(.NBUF(NBUF)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .ovf_err(ovf_err),
  .rd_release(rd_release), .rd_corr(rd_corr), .frame_rdy(frame_rdy)
);

// File: tb/tb_trig_pipe_derand.sv
module tb_trig_pipe_derand;
  logic        clk = 0, rst_n = 0;
  logic [11:0] smp_data = 0, bx_num = 0;
  logic        smp_bad = 0, bypass = 0, accept = 0, rd_release = 0;
  logic [1:0]  smp_pu = 0;
  logic [8:0]  delay_len = 9'd10;
  logic [4:0]  frame_len = 5'd6;
  logic [2:0]  rd_sel = 0;
  logic [3:0]  rd_addr = 0;
  logic [14:0] rd_data;
  logic        rd_corr, ovf_err;
  logic [7:0]  frame_rdy;

  int tests = 0, fails = 0, edge_n = 0, rc = 0;
  int ns [9];

  trig_pipe_derand dut (
    .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_bad(smp_bad),
    .smp_pu(smp_pu), .delay_len(delay_len), .bypass(bypass),
    .frame_len(frame_len), .accept(accept), .bx_num(bx_num),
    .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_release(rd_release),
    .rd_data(rd_data), .rd_corr(rd_corr), .frame_rdy(frame_rdy),
    .ovf_err(ovf_err));

  always #10 clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;

  function automatic logic [11:0] sdata(int m); return 12'((m * 37 + 5) & 32'hFFF); endfunction
  function automatic logic sbad(int m); return (m % 11) == 3; endfunction
  function automatic logic [1:0] spu(int m); return {(m % 13) == 0, (m % 7) == 0}; endfunction
  function automatic logic [11:0] sbx(int m); return 12'((m * 3 + 100) & 32'hFFF); endfunction
  function automatic logic [14:0] wexp(int m); return {sbad(m), spu(m), sdata(m)}; endfunction

  always @(negedge clk) begin
    smp_data = sdata(edge_n);
    smp_bad  = sbad(edge_n);
    smp_pu   = spu(edge_n);
    bx_num   = sbx(edge_n);
  end

  // stimulus: delay_len, expected delay, frame_len, expected length, bypass, gap to 2nd accept
  localparam int TBL [8][6] = '{
    '{ 10,  10,  6,  6, 0,  0},
    '{  0,   4, 16, 16, 0,  0},
    '{300, 256,  5,  5, 0,  2},
    '{ 37,  37,  1,  2, 0,  0},
    '{ 20,  20, 31, 16, 0,  1},
    '{  7,   7,  8,  8, 1,  3},
    '{256, 256, 16, 16, 0, 15},
    '{  4,   4,  3,  3, 0,  5}};

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic read_frame(input int b, input int n, input int f, input int d, input string rq);
    logic [14:0] hdr;
    hdr = {3'b000, sbx(n)};
    for (int a = 1; a < f; a++) begin
      hdr[14]    = hdr[14] | sbad(n - d + a - 1);
      hdr[13:12] = hdr[13:12] | spu(n - d + a - 1);
    end
    for (int a = 0; a < f; a++) begin
      @(negedge clk);
      rd_sel = 3'(b);
      rd_addr = 4'(a);
      @(negedge clk);
      if (a == 0) check("R6 header", 32'(rd_data), 32'(hdr));
      else if (a == 1) check(rq, 32'(rd_data), 32'(wexp(n - d)));
      else check("R4 R5 sample", 32'(rd_data), 32'(wexp(n - d + a - 1)));
      if (a == 0) check("R11 corr", 32'(rd_corr), 0);
    end
  endtask

  task automatic release_buf(input int b);
    @(negedge clk);
    rd_sel = 3'(b);
    rd_release = 1;
    @(negedge clk);
    rd_release = 0;
    check("R10 release", 32'(frame_rdy[b]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 frame_rdy", 32'(frame_rdy), 0);
    check("R1 ovf_err", 32'(ovf_err), 0);
    check("R1 rd_data", 32'(rd_data), 0);
    check("R1 rd_corr", 32'(rd_corr), 0);

    for (int r = 0; r < 8; r++) begin
      int d, f, g, n1, n2;
      logic [7:0] m;
      @(negedge clk);
      delay_len = 9'(TBL[r][0]);
      frame_len = 5'(TBL[r][2]);
      bypass = TBL[r][4] != 0;
      repeat (600) @(negedge clk);
      d = bypass ? 0 : TBL[r][1];
      f = TBL[r][3];
      g = TBL[r][5];
      accept = 1;
      n1 = edge_n;
      n2 = n1 + g;
      for (int c = 1; c <= g; c++) begin
        @(negedge clk);
        accept = (c == g);
      end
      @(negedge clk);
      accept = 0;
      repeat (40) @(negedge clk);
      m = 8'(1 << (rc % 8));
      if (g != 0) m = m | 8'(1 << ((rc + 1) % 8));
      check("R7 ring order", 32'(frame_rdy), 32'(m));
      read_frame(rc % 8, n1, f, d, bypass ? "R3 bypass" : "R2 delay");
      release_buf(rc % 8);
      rc++;
      if (g != 0) begin
        read_frame(rc % 8, n2, f, d, "R8 overlap");
        release_buf(rc % 8);
        rc++;
      end
    end

    @(negedge clk);
    delay_len = 9'd10;
    frame_len = 5'd16;
    bypass = 0;
    repeat (600) @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      accept = 1;
      ns[i] = edge_n;
      @(negedge clk);
    end
    accept = 0;
    check("R9 ovf pulse", 32'(ovf_err), 1);
    @(negedge clk);
    check("R9 ovf one cycle", 32'(ovf_err), 0);
    repeat (40) @(negedge clk);
    check("R8 all ready", 32'(frame_rdy), 32'hFF);
    for (int i = 0; i < 8; i++) read_frame((rc + i) % 8, ns[i], 16, 10, "R8 burst");

    @(negedge clk);
    rd_sel = 3'(rc % 8);
    rd_release = 1;
    accept = 1;
    ns[0] = edge_n;
    @(negedge clk);
    rd_release = 0;
    accept = 0;
    check("R10 same-cycle no ovf", 32'(ovf_err), 0);
    repeat (40) @(negedge clk);
    check("R10 refilled", 32'(frame_rdy), 32'hFF);
    read_frame(rc % 8, ns[0], 16, 10, "R10 refill");

    @(negedge clk);
    accept = 1;
    @(negedge clk);
    accept = 0;
    check("R9 ovf when ready", 32'(ovf_err), 1);
    repeat (40) @(negedge clk);
    check("R9 rdy unchanged", 32'(frame_rdy), 32'hFF);
    read_frame((rc + 1) % 8, ns[1], 16, 10, "R9 content kept");

    for (int b = 0; b < 8; b++) release_buf(b);
    check("R10 all released", 32'(frame_rdy), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule